// File: doc/BRIEF.md
# Floating Bus Value Generator

This block works out which byte the CPU sees when it reads a bus that no memory or port is driving. While the video engine is fetching display data, that byte is the most recent pixel or attribute byte the engine captured. In every other case it is an idle value.

The parent sequencer supplies three kinds of input:
- the video engine's fetch writes, tagged with their slot;
- the frame line counter and the half-cycle position within the line;
- completed memory transfers, each with a flag that says whether the slot is contended.

The CPU side supplies the address, read strobes, a flag that says whether some other port device claimed the input cycle, and the paging-lock flag.

The block returns two things: the floating byte, and a strobe that says when the parent should put that byte on the data bus. On the gate-array model the parent ANDs the byte into the port result. The machine model is a parameter. It selects three behaviours:
- the idle value;
- whether bit 0 of a video byte is forced high;
- which bus cycles expose the floating value.

Top module: `fbus_gen`

## Requirements
- R1: After reset every fetch slot and the contended-transfer capture hold 0xFF, so every model returns 0xFF from any line and time.
- R2: When the line counter is 192 or more, the output is the idle value.
- R3: Within a line, the output is the idle value when the half-cycle time is 256 or more, or when bit 3 of the time is 1.
- R4: Otherwise the output is the captured byte of slot time[2:1]. Slot 0 is a pixel byte, 1 an attribute byte, 2 a pixel byte and 3 an attribute byte.
- R5: A fetch write to slot s with data d changes only slot s, and it is visible from the cycle after the write's clock edge.
- R6: In the gate-array model, the idle value is the data of the last completed memory transfer whose contended flag was 1. Transfers with the flag at 0 leave it unchanged. Bit 0 of this idle value is not forced.
- R7: In the 16K, 48K and 128K models, the idle value is always 0xFF, whatever memory traffic occurs.
- R8: In the gate-array model, bit 0 of every returned video byte reads 1. In the other models the video byte is returned unmodified.
- R9: In the gate-array model, float_drive is high exactly when io_rd is high, (cpu_addr & 0xF003) == 0x0001 and paging_lock is 0. Memory reads never drive.
- R10: In the gate-array model, paging_lock = 1 suppresses float_drive on any port address.
- R11: In the 16K, 48K and 128K models, an io_rd with port_claimed = 0 drives the floating value. An io_rd with port_claimed = 1 does not.
- R12: Only in the 16K model, a mem_rd at address 0x8000 or above drives the floating value. A mem_rd below 0x8000 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_we | input | 1 | Video engine captured a byte this cycle |
| fetch_slot | input | 2 | Slot of the captured byte (0 pixel, 1 attribute, 2 pixel, 3 attribute) |
| fetch_data | input | 8 | Captured video byte |
| line_cnt | input | 9 | Current frame line |
| line_time | input | 9 | Half-cycles into the current line |
| mem_done | input | 1 | A CPU memory read or write completed this cycle |
| mem_contended | input | 1 | The completed transfer hit a contended slot |
| mem_data | input | 8 | Data of the completed transfer |
| paging_lock | input | 1 | Paging register locked |
| cpu_addr | input | 16 | CPU address |
| io_rd | input | 1 | CPU port read in progress |
| mem_rd | input | 1 | CPU memory read in progress |
| port_claimed | input | 1 | Another port device decodes this input cycle |
| float_data | output | 8 | Floating bus byte |
| float_drive | output | 1 | Parent should place float_data on the bus |

## Verification
The bench builds four copies of the block side by side from the same stimulus: the 16K, 48K, 128K and gate-array model values. A single run can therefore compare them. Only the gate-array copy reveals contended-transfer capture and the forced low bit. Only the 16K copy reaches the upper-memory drive path. The three classic copies together expose the unclaimed-port path and the constant 0xFF idle value.

// File: rtl/fbus_pkg.sv
package fbus_pkg;

    typedef enum logic [1:0] {
        MDL_16K  = 2'd0,
        MDL_48K  = 2'd1,
        MDL_128K = 2'd2,
        MDL_GA   = 2'd3
    } fbus_model_e;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    localparam logic [15:0] GA_PORT_MASK  = 16'hF003;
    localparam logic [15:0] GA_PORT_MATCH = 16'h0001;
    localparam logic [15:0] NOMEM_BASE    = 16'h8000;

    typedef struct packed {
        logic              done;
        logic              contended;
        logic [BYTE_W-1:0] data;
    } mem_evt_t;

    function automatic logic tracks_contended(fbus_model_e m);
        return m == MDL_GA;
    endfunction

    function automatic logic forces_lsb(fbus_model_e m);
        return m == MDL_GA;
    endfunction

endpackage

// File: rtl/fbus_window.sv
module fbus_window #(
    parameter int LINE_W        = 9,
    parameter int TIME_W        = 9,
    parameter int VISIBLE_LINES = 192,
    parameter int ACTIVE_HALF   = 256,
    parameter int NUM_SLOTS     = 4
) (
    input  logic [LINE_W-1:0]            line_cnt,
    input  logic [TIME_W-1:0]            line_time,
    output logic                         open,
    output logic [$clog2(NUM_SLOTS)-1:0] idx
);
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int GROUP_BIT = SLOT_W + 1;

    logic row_ok;
    logic col_ok;

    always_comb begin
        row_ok = line_cnt < LINE_W'(VISIBLE_LINES);
        col_ok = (line_time < TIME_W'(ACTIVE_HALF)) && !line_time[GROUP_BIT];
        open   = row_ok && col_ok;
        idx    = line_time[SLOT_W:1];
    end
endmodule

// File: rtl/fbus_fetch_latch.sv
module fbus_fetch_latch
    import fbus_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 we,
    input  logic [$clog2(NUM_SLOTS)-1:0]         slot,
    input  logic [BYTE_W-1:0]                    data,
    output logic [NUM_SLOTS-1:0][BYTE_W-1:0]     bytes
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= IDLE_BYTE;
            else if (we && slot == SLOT_W'(g))
                q <= data;
        end
        assign bytes[g] = q;
    end
endmodule

// File: rtl/fbus_idle_latch.sv
module fbus_idle_latch
    import fbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mem_evt_t          evt,
    output logic [BYTE_W-1:0] last
);
    always_ff @(posedge clk) begin
        if (rst)
            last <= IDLE_BYTE;
        else if (evt.done && evt.contended)
            last <= evt.data;
    end
endmodule

// File: rtl/fbus_gen.sv
module fbus_gen
    import fbus_pkg::*;
#(
    parameter fbus_model_e MODEL  = MDL_GA,
    parameter int LINE_W          = 9,
    parameter int TIME_W          = 9,
    parameter int VISIBLE_LINES   = 192,
    parameter int ACTIVE_HALF     = 256,
    parameter int NUM_SLOTS       = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fetch_we,
    input  logic [$clog2(NUM_SLOTS)-1:0] fetch_slot,
    input  logic [7:0]                   fetch_data,
    input  logic [LINE_W-1:0]            line_cnt,
    input  logic [TIME_W-1:0]            line_time,
    input  logic                         mem_done,
    input  logic                         mem_contended,
    input  logic [7:0]                   mem_data,
    input  logic                         paging_lock,
    input  logic [15:0]                  cpu_addr,
    input  logic                         io_rd,
    input  logic                         mem_rd,
    input  logic                         port_claimed,
    output logic [7:0]                   float_data,
    output logic                         float_drive
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS-1:0][BYTE_W-1:0] slots;
    logic [BYTE_W-1:0]                contended_last;
    logic                             win_open;
    logic [SLOT_W-1:0]                win_idx;
    mem_evt_t                         evt;
    logic [BYTE_W-1:0]                video_byte;
    logic [BYTE_W-1:0]                idle_byte;

    assign evt = '{done: mem_done, contended: mem_contended, data: mem_data};

    fbus_fetch_latch #(.NUM_SLOTS(NUM_SLOTS)) u_fetch (
        .clk   (clk),
        .rst   (rst),
        .we    (fetch_we),
        .slot  (fetch_slot),
        .data  (fetch_data),
        .bytes (slots)
    );

    fbus_idle_latch u_idle (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .last (contended_last)
    );

    fbus_window #(
        .LINE_W        (LINE_W),
        .TIME_W        (TIME_W),
        .VISIBLE_LINES (VISIBLE_LINES),
        .ACTIVE_HALF   (ACTIVE_HALF),
        .NUM_SLOTS     (NUM_SLOTS)
    ) u_win (
        .line_cnt  (line_cnt),
        .line_time (line_time),
        .open      (win_open),
        .idx       (win_idx)
    );

    always_comb begin
        video_byte = slots[win_idx];
        if (forces_lsb(MODEL))
            video_byte[0] = 1'b1;
        idle_byte  = tracks_contended(MODEL) ? contended_last : IDLE_BYTE;
        float_data = win_open ? video_byte : idle_byte;
    end

    logic ga_hit;
    logic unclaimed_hit;
    logic highmem_hit;

    always_comb begin
        ga_hit        = io_rd && ((cpu_addr & GA_PORT_MASK) == GA_PORT_MATCH) && !paging_lock;
        unclaimed_hit = io_rd && !port_claimed;
        highmem_hit   = mem_rd && (cpu_addr >= NOMEM_BASE);
    end

    if (MODEL == MDL_GA) begin : g_drv_ga
        assign float_drive = ga_hit;
    end else if (MODEL == MDL_16K) begin : g_drv_16k
        assign float_drive = unclaimed_hit || highmem_hit;
    end else begin : g_drv_classic
        assign float_drive = unclaimed_hit;
    end
endmodule

// File: rtl/fbus_gen_chk.sv
module fbus_gen_chk
    import fbus_pkg::*;
#(
    parameter fbus_model_e MODEL  = MDL_GA,
    parameter int LINE_W          = 9,
    parameter int TIME_W          = 9,
    parameter int VISIBLE_LINES   = 192,
    parameter int ACTIVE_HALF     = 256,
    parameter int NUM_SLOTS       = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         fetch_we,
    input logic [$clog2(NUM_SLOTS)-1:0] fetch_slot,
    input logic [7:0]                   fetch_data,
    input logic [LINE_W-1:0]            line_cnt,
    input logic [TIME_W-1:0]            line_time,
    input logic                         mem_done,
    input logic                         mem_contended,
    input logic [7:0]                   mem_data,
    input logic                         paging_lock,
    input logic                         io_rd,
    input logic                         mem_rd,
    input logic [7:0]                   float_data,
    input logic                         float_drive
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam logic IS_GA = (MODEL == MDL_GA);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    logic in_win;
    assign in_win = (line_cnt < LINE_W'(VISIBLE_LINES)) &&
                    (line_time < TIME_W'(ACTIVE_HALF)) && !line_time[SLOT_W+1];

    // R2
    idle_rows_chk: assert property (@(posedge clk) disable iff (rst)
        (!IS_GA && line_cnt >= LINE_W'(VISIBLE_LINES)) |-> float_data == 8'hFF);

    // R6
    contended_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (IS_GA && past_ok && $past(mem_done && mem_contended) && !in_win)
        |-> float_data == $past(mem_data));

    // R5
    fetch_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(fetch_we) && in_win && line_time[SLOT_W:1] == $past(fetch_slot))
        |-> float_data == ($past(fetch_data) | {7'd0, IS_GA}));

    // R8
    lsb_forced_chk: assert property (@(posedge clk) disable iff (rst)
        (IS_GA && in_win) |-> float_data[0]);

    // R10
    lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (IS_GA && paging_lock) |-> !float_drive);

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (!io_rd && !mem_rd) |-> !float_drive);
endmodule

bind fbus_gen fbus_gen_chk #(
    .MODEL         (MODEL),
    .LINE_W        (LINE_W),
    .TIME_W        (TIME_W),
    .VISIBLE_LINES (VISIBLE_LINES),
    .ACTIVE_HALF   (ACTIVE_HALF),
    .NUM_SLOTS     (NUM_SLOTS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .fetch_we      (fetch_we),
    .fetch_slot    (fetch_slot),
    .fetch_data    (fetch_data),
    .line_cnt      (line_cnt),
    .line_time     (line_time),
    .mem_done      (mem_done),
    .mem_contended (mem_contended),
    .mem_data      (mem_data),
    .paging_lock   (paging_lock),
    .io_rd         (io_rd),
    .mem_rd        (mem_rd),
    .float_data    (float_data),
    .float_drive   (float_drive)
);

// File: tb/tb_fbus_gen.sv
module tb_fbus_gen;
    import fbus_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_we = 1'b0;
    logic [1:0]  fetch_slot = 2'd0;
    logic [7:0]  fetch_data = 8'd0;
    logic [8:0]  line_cnt = 9'd0;
    logic [8:0]  line_time = 9'd0;
    logic        mem_done = 1'b0;
    logic        mem_contended = 1'b0;
    logic [7:0]  mem_data = 8'd0;
    logic        paging_lock = 1'b0;
    logic [15:0] cpu_addr = 16'd0;
    logic        io_rd = 1'b0;
    logic        mem_rd = 1'b0;
    logic        port_claimed = 1'b0;

    logic [7:0] fd_ga, fd_16, fd_48, fd_128;
    logic       dr_ga, dr_16, dr_48, dr_128;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fbus_gen #(.MODEL(MDL_GA)) dut (
        .clk(clk), .rst(rst), .fetch_we(fetch_we), .fetch_slot(fetch_slot),
        .fetch_data(fetch_data), .line_cnt(line_cnt), .line_time(line_time),
        .mem_done(mem_done), .mem_contended(mem_contended), .mem_data(mem_data),
        .paging_lock(paging_lock), .cpu_addr(cpu_addr), .io_rd(io_rd),
        .mem_rd(mem_rd), .port_claimed(port_claimed),
        .float_data(fd_ga), .float_drive(dr_ga));

    fbus_gen #(.MODEL(MDL_16K)) dut_16k (
        .clk(clk), .rst(rst), .fetch_we(fetch_we), .fetch_slot(fetch_slot),
        .fetch_data(fetch_data), .line_cnt(line_cnt), .line_time(line_time),
        .mem_done(mem_done), .mem_contended(mem_contended), .mem_data(mem_data),
        .paging_lock(paging_lock), .cpu_addr(cpu_addr), .io_rd(io_rd),
        .mem_rd(mem_rd), .port_claimed(port_claimed),
        .float_data(fd_16), .float_drive(dr_16));

    fbus_gen #(.MODEL(MDL_48K)) dut_48k (
        .clk(clk), .rst(rst), .fetch_we(fetch_we), .fetch_slot(fetch_slot),
        .fetch_data(fetch_data), .line_cnt(line_cnt), .line_time(line_time),
        .mem_done(mem_done), .mem_contended(mem_contended), .mem_data(mem_data),
        .paging_lock(paging_lock), .cpu_addr(cpu_addr), .io_rd(io_rd),
        .mem_rd(mem_rd), .port_claimed(port_claimed),
        .float_data(fd_48), .float_drive(dr_48));

    fbus_gen #(.MODEL(MDL_128K)) dut_128k (
        .clk(clk), .rst(rst), .fetch_we(fetch_we), .fetch_slot(fetch_slot),
        .fetch_data(fetch_data), .line_cnt(line_cnt), .line_time(line_time),
        .mem_done(mem_done), .mem_contended(mem_contended), .mem_data(mem_data),
        .paging_lock(paging_lock), .cpu_addr(cpu_addr), .io_rd(io_rd),
        .mem_rd(mem_rd), .port_claimed(port_claimed),
        .float_data(fd_128), .float_drive(dr_128));

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_fetch(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        fetch_we = 1'b1; fetch_slot = s; fetch_data = d;
        @(negedge clk);
        fetch_we = 1'b0;
    endtask

    task automatic put_mem(logic c, logic [7:0] d);
        @(negedge clk);
        mem_done = 1'b1; mem_contended = c; mem_data = d;
        @(negedge clk);
        mem_done = 1'b0; mem_contended = 1'b0;
    endtask

    task automatic look(int ln, int tm);
        @(negedge clk);
        line_cnt = 9'(ln); line_time = 9'(tm);
        #1;
    endtask

    task automatic t_reset;
        look(0, 0);
        chk("R1 ga", fd_ga, 8'hFF);
        chk("R1 16k", fd_16, 8'hFF);
        chk("R1 128k", fd_128, 8'hFF);
        look(250, 300);
        chk("R1 ga idle", fd_ga, 8'hFF);
    endtask

    task automatic t_fetch;
        put_fetch(2'd0, 8'h12);
        put_fetch(2'd1, 8'h34);
        put_fetch(2'd2, 8'h56);
        put_fetch(2'd3, 8'h78);
        look(5, 0);  chk("R4 slot0 48k", fd_48, 8'h12);
        chk("R8 ga lsb", fd_ga, 8'h13);
        look(5, 2);  chk("R4 slot1 48k", fd_48, 8'h34);
        look(5, 4);  chk("R4 slot2 48k", fd_48, 8'h56);
        look(5, 6);  chk("R4 slot3 48k", fd_48, 8'h78);
        chk("R8 ga slot3", fd_ga, 8'h79);
        look(5, 1);  chk("R4 odd time 16k", fd_16, 8'h12);
    endtask

    task automatic t_window;
        look(5, 8);    chk("R3 bit3 48k", fd_48, 8'hFF);
        look(5, 256);  chk("R3 time256 48k", fd_48, 8'hFF);
        look(5, 246);  chk("R3 time246 48k", fd_48, 8'h78);
        look(191, 2);  chk("R2 line191 48k", fd_48, 8'h34);
        look(192, 2);  chk("R2 line192 48k", fd_48, 8'hFF);
        chk("R2 line192 ga", fd_ga, 8'hFF);
    endtask

    task automatic t_slot_only;
        put_fetch(2'd2, 8'hA0);
        look(5, 4);  chk("R5 slot2 new", fd_48, 8'hA0);
        chk("R5 slot2 ga", fd_ga, 8'hA1);
        look(5, 0);  chk("R5 slot0 kept", fd_48, 8'h12);
        look(5, 6);  chk("R5 slot3 kept", fd_48, 8'h78);
    endtask

    task automatic t_contended;
        put_mem(1'b1, 8'h5A);
        put_mem(1'b0, 8'h33);
        look(200, 10);  chk("R6 ga idle", fd_ga, 8'h5A);
        chk("R7 48k idle", fd_48, 8'hFF);
        chk("R7 128k idle", fd_128, 8'hFF);
        look(5, 8);     chk("R6 ga idle in line", fd_ga, 8'h5A);
        look(5, 0);     chk("R6 ga video kept", fd_ga, 8'h13);
        put_mem(1'b1, 8'hC4);
        look(300, 0);   chk("R6 ga idle update", fd_ga, 8'hC4);
    endtask

    task automatic t_drive_ga;
        @(negedge clk);
        io_rd = 1'b1; port_claimed = 1'b1; cpu_addr = 16'h0FFD; #1;
        chk("R9 ga hit", {7'd0, dr_ga}, 8'd1);
        cpu_addr = 16'h1FFD; #1;
        chk("R9 ga miss 1ffd", {7'd0, dr_ga}, 8'd0);
        cpu_addr = 16'h0003; #1;
        chk("R9 ga miss 0003", {7'd0, dr_ga}, 8'd0);
        cpu_addr = 16'h0001; paging_lock = 1'b1; #1;
        chk("R10 ga locked", {7'd0, dr_ga}, 8'd0);
        paging_lock = 1'b0; io_rd = 1'b0; mem_rd = 1'b1; cpu_addr = 16'h9000; #1;
        chk("R9 ga memrd", {7'd0, dr_ga}, 8'd0);
        mem_rd = 1'b0;
    endtask

    task automatic t_drive_classic;
        @(negedge clk);
        io_rd = 1'b1; port_claimed = 1'b0; cpu_addr = 16'h00FF; #1;
        chk("R11 48k unclaimed", {7'd0, dr_48}, 8'd1);
        chk("R11 128k unclaimed", {7'd0, dr_128}, 8'd1);
        chk("R11 16k unclaimed", {7'd0, dr_16}, 8'd1);
        port_claimed = 1'b1; #1;
        chk("R11 48k claimed", {7'd0, dr_48}, 8'd0);
        io_rd = 1'b0; port_claimed = 1'b0; mem_rd = 1'b1; cpu_addr = 16'h8000; #1;
        chk("R12 16k high", {7'd0, dr_16}, 8'd1);
        chk("R12 48k high", {7'd0, dr_48}, 8'd0);
        cpu_addr = 16'h7FFF; #1;
        chk("R12 16k low", {7'd0, dr_16}, 8'd0);
        mem_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_fetch;
        t_window;
        t_slot_only;
        t_contended;
        t_drive_ga;
        t_drive_classic;
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule